// File: doc/BRIEF.md
# Burst Column Address Generator

This block generates the sequence of column addresses for a single burst access to one bank of a synchronous DRAM. A start request loads a starting column, a burst-length code and an ordering type. The block then issues one column address per clock, flagged by `valid`, and raises `last` alongside the final address of a fixed-length burst.

Two orderings are supported. Sequential ordering counts upward inside an aligned block whose size is the burst length. Interleaved ordering XORs the beat number into the low column bits. A full-page burst walks the whole row modulo the row width and runs until it is stopped. A stop request ends any burst; the same input serves both a burst-stop and a precharge. A start on any clock abandons the current burst and begins a new one at the new column.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `valid` and `last` are 0 and `colAddr` is 0.
- R2: A start sampled on a rising edge makes `valid`=1 and `colAddr`=`startCol` (beat 0) from that edge. Each following edge presents the next beat until the burst ends.
- R3: The `burstLen` codes are decoded as follows:
  - 0 gives 1 beat, 1 gives 2 beats, 2 gives 4 beats and 3 gives 8 beats.
  - 7 selects full page.
  - The reserved codes 4, 5 and 6 give 1 beat.
- R4: With `burstType`=0 (sequential) and a burst length BL of 2, 4 or 8, beat i has low log2(BL) bits equal to (startCol+i) mod BL. The upper bits stay equal to those of `startCol`.
- R5: With `burstType`=1 (interleaved) and BL of 2, 4 or 8, beat i equals `startCol` XOR i, with i confined to the low log2(BL) bits.
- R6: In full page, beat i is (startCol+i) mod 512, and `burstType` is ignored. The burst continues until a stop or a new start, and `last` is never 1.
- R7: In a fixed-length burst, `last`=1 exactly on beat BL-1. On the following edge `valid` and `last` drop to 0, unless a start is sampled there.
- R8: A stop sampled without a start makes `valid` and `last` 0 from that edge. `colAddr` then holds its value.
- R9: A start is accepted on any cycle, including mid-burst, and restarts the sequence at the new column. When start and stop are sampled together, start wins.
- R10: `burstLen` and `burstType` are sampled only with start. Changes to them during a burst have no effect on the addresses or on `last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a burst at `startCol` |
| startCol | input | 9 | Starting column |
| burstLen | input | 3 | Burst-length code (see R3) |
| burstType | input | 1 | 0 sequential, 1 interleaved |
| stop | input | 1 | Terminate the current burst |
| colAddr | output | 9 | Current column address |
| valid | output | 1 | `colAddr` is a burst beat |
| last | output | 1 | Final beat of a fixed-length burst |

## Verification
The assertions check on every cycle the following properties:
- `last` only appears with `valid`.
- A start loads `startCol` onto `colAddr` at the next edge.
- A lone stop, or the edge after `last`, clears `valid`.
- A single-beat code flags `last` at once.
- A full-page start never flags it.

The exact address orderings depend on the start column and the beat number:
- the wrap inside the aligned block,
- the XOR pattern,
- the wrap across column 511,
- the ignored mid-burst mode changes.

These are shown only by the bench's directed scenarios. The bench compares every beat against a model computed from the requirements.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;        // capture a new start column
    logic step;        // advance to the next beat
    logic interleave;  // ordering for the burst being loaded
  } ctrlStrobe_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int COL_W    = 9,
  parameter int LEN_W    = 3,
  parameter int MAX_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] burstLen,
  input  logic             burstType,
  input  logic             stop,
  output ctrlStrobe_t      strobe,
  output logic [COL_W-1:0] lenMask,
  output logic             valid,
  output logic             last
);
  logic             codeFull;
  logic [COL_W-1:0] codeMask;
  logic             active;
  logic             fullQ;
  logic [COL_W-1:0] remain;
  logic             atEnd;

  // Length decode: all-ones code selects full page, short codes give 2^code,
  // anything else falls back to a single beat.
  always_comb begin
    codeFull = &burstLen;
    codeMask = '0;
    if (codeFull) begin
      codeMask = '1;
    end else if (int'(burstLen) <= MAX_LOG2) begin
      codeMask = (COL_W'(1) << burstLen) - COL_W'(1);
    end
  end

  assign atEnd = ~fullQ && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      fullQ  <= 1'b0;
      remain <= '0;
    end else if (start) begin
      active <= 1'b1;
      fullQ  <= codeFull;
      remain <= codeMask;
    end else if (stop) begin
      active <= 1'b0;
    end else if (active) begin
      if (atEnd) begin
        active <= 1'b0;
      end else if (!fullQ) begin
        remain <= remain - COL_W'(1);
      end
    end
  end

  always_comb begin
    strobe.load       = start;
    strobe.interleave = burstType & ~codeFull;
    strobe.step       = active & ~start & ~stop & ~atEnd;
  end

  assign lenMask = codeMask;
  assign valid   = active;
  assign last    = active & atEnd;
endmodule

// File: rtl/burst_dp.sv
module burst_dp
  import burst_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  logic [COL_W-1:0] lenMask,
  input  logic [COL_W-1:0] startCol,
  output logic [COL_W-1:0] colAddr
);
  logic [COL_W-1:0] baseQ;
  logic [COL_W-1:0] maskQ;
  logic             ilvQ;
  logic [COL_W-1:0] idxQ;
  logic [COL_W-1:0] colQ;
  logic [COL_W-1:0] nextIdx;
  logic [COL_W-1:0] nextCol;

  always_comb begin
    nextIdx = idxQ + COL_W'(1);
    if (ilvQ) begin
      nextCol = baseQ ^ (nextIdx & maskQ);
    end else begin
      nextCol = (colQ & ~maskQ) | ((colQ + COL_W'(1)) & maskQ);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseQ <= '0;
      maskQ <= '0;
      ilvQ  <= 1'b0;
      idxQ  <= '0;
      colQ  <= '0;
    end else if (strobe.load) begin
      baseQ <= startCol;
      maskQ <= lenMask;
      ilvQ  <= strobe.interleave;
      idxQ  <= '0;
      colQ  <= startCol;
    end else if (strobe.step) begin
      idxQ  <= nextIdx;
      colQ  <= nextCol;
    end
  end

  assign colAddr = colQ;
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_pkg::*;
#(
  parameter int COL_W    = 9,
  parameter int LEN_W    = 3,
  parameter int MAX_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] burstLen,
  input  logic             burstType,
  input  logic             stop,
  output logic [COL_W-1:0] colAddr,
  output logic             valid,
  output logic             last
);
  ctrlStrobe_t      strobe;
  logic [COL_W-1:0] lenMask;

  burst_ctrl #(.COL_W(COL_W), .LEN_W(LEN_W), .MAX_LOG2(MAX_LOG2)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .burstLen(burstLen),
    .burstType(burstType), .stop(stop), .strobe(strobe),
    .lenMask(lenMask), .valid(valid), .last(last)
  );

  burst_dp #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .lenMask(lenMask),
    .startCol(startCol), .colAddr(colAddr)
  );
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 9,
  parameter int LEN_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] startCol,
  input logic [LEN_W-1:0] burstLen,
  input logic             stop,
  input logic [COL_W-1:0] colAddr,
  input logic             valid,
  input logic             last
);
  // R7
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);

  // R2
  start_loads_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (valid && colAddr == $past(startCol)));

  // R8
  stop_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> (!valid && !last));

  // R7
  end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> !valid);

  // R3
  single_beat_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && burstLen == '0) |=> last);

  // R6
  full_page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (&burstLen)) |=> !last);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .startCol(startCol),
  .burstLen(burstLen), .stop(stop), .colAddr(colAddr),
  .valid(valid), .last(last)
);

// File: tb/burst_col_gen_bench.sv
`timescale 1ns/100ps
module burst_col_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [8:0] startCol = '0;
  logic [2:0] burstLen = '0;
  logic       burstType = 1'b0;
  logic       stop = 1'b0;
  logic [8:0] colAddr;
  logic       valid;
  logic       last;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_col_gen u_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .startCol(startCol),
    .burstLen(burstLen), .burstType(burstType), .stop(stop),
    .colAddr(colAddr), .valid(valid), .last(last)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int beatsOf(input int code);
    if (code == 7) return 0;       // full page
    if (code <= 3) return 1 << code;
    return 1;
  endfunction

  function automatic int expCol(input int s, input int code, input int typ, input int i);
    int m;
    if (code == 7) return (s + i) % 512;
    m = beatsOf(code) - 1;
    if (typ != 0) return s ^ (i & m);
    return (s & ~m) | ((s + i) & m);
  endfunction

  // Launch: drive start for one edge; return at the negedge after it.
  task automatic launch(input int s, input int code, input int typ, input bit withStop);
    @(negedge clk);
    start = 1'b1; startCol = 9'(s); burstLen = 3'(code); burstType = typ[0];
    stop = withStop;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
  endtask

  // Check a whole fixed burst, optionally scrambling mode inputs mid-burst.
  task automatic runBurst(input string req, input int s, input int code,
                          input int typ, input bit scramble);
    int bl;
    bl = beatsOf(code);
    launch(s, code, typ, 1'b0);
    for (int i = 0; i < bl; i++) begin
      check({req, " valid"}, int'(valid), 1);
      check({req, " col"}, int'(colAddr), expCol(s, code, typ, i));
      check({req, " last"}, int'(last), (i == bl - 1) ? 1 : 0);
      if (scramble && i == 0) begin
        burstLen = 3'd7; burstType = ~burstType;
      end
      @(negedge clk);
    end
    check({req, " end valid"}, int'(valid), 0);
    check({req, " end last"}, int'(last), 0);
  endtask

  task automatic testReset();
    check("R1 valid", int'(valid), 0);
    check("R1 last", int'(last), 0);
    check("R1 col", int'(colAddr), 0);
  endtask

  task automatic testFullPage();
    launch(508, 7, 1, 1'b0);
    for (int i = 0; i < 10; i++) begin
      check("R6 full col", int'(colAddr), (508 + i) % 512);
      check("R6 full last", int'(last), 0);
      check("R6 full valid", int'(valid), 1);
      @(negedge clk);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check("R8 stop valid", int'(valid), 0);
    check("R8 stop col hold", int'(colAddr), (508 + 10) % 512);
  endtask

  task automatic testStop();
    launch(9'h0B3, 3, 0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      check("R4 pre-stop col", int'(colAddr), expCol(9'h0B3, 3, 0, i));
      if (i < 2) @(negedge clk);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check("R8 valid", int'(valid), 0);
    check("R8 last", int'(last), 0);
    check("R8 col hold", int'(colAddr), expCol(9'h0B3, 3, 0, 2));
    @(negedge clk);
    check("R8 stays idle", int'(valid), 0);
  endtask

  task automatic testRestart();
    launch(9'h1F5, 3, 1, 1'b0);
    check("R9 first col", int'(colAddr), 9'h1F5);
    @(negedge clk);
    check("R9 second col", int'(colAddr), expCol(9'h1F5, 3, 1, 1));
    // restart mid-burst together with stop: start wins
    runBurst("R9 restart", 9'h0A2, 2, 0, 1'b0);
    launch(9'h055, 2, 1, 1'b1);
    for (int i = 0; i < 4; i++) begin
      check("R9 start beats stop col", int'(colAddr), expCol(9'h055, 2, 1, i));
      check("R9 start beats stop valid", int'(valid), 1);
      @(negedge clk);
    end
    check("R9 end", int'(valid), 0);
  endtask

  task automatic testBackToBack();
    // new start on the edge where last is shown
    launch(9'h010, 1, 0, 1'b0);
    @(negedge clk);
    check("R7 last before restart", int'(last), 1);
    start = 1'b1; startCol = 9'h123; burstLen = 3'd0; burstType = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check("R7 restart on last valid", int'(valid), 1);
    check("R7 restart on last col", int'(colAddr), 9'h123);
    check("R3 BL1 last", int'(last), 1);
    @(negedge clk);
    check("R7 idle after", int'(valid), 0);
  endtask

  initial begin
    testReset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    runBurst("R3 BL1", 9'h1AB, 0, 0, 1'b0);
    runBurst("R3 BL2 R4", 9'h0FF, 1, 0, 1'b0);
    runBurst("R4 BL4", 9'h06E, 2, 0, 1'b0);
    runBurst("R4 BL8", 9'h13D, 3, 0, 1'b0);
    runBurst("R5 BL2", 9'h0C1, 1, 1, 1'b0);
    runBurst("R5 BL4", 9'h0C6, 2, 1, 1'b0);
    runBurst("R5 BL8", 9'h1FB, 3, 1, 1'b0);
    runBurst("R3 reserved5", 9'h044, 5, 1, 1'b0);
    runBurst("R10 scramble seq", 9'h0D5, 3, 0, 1'b1);
    runBurst("R10 scramble ilv", 9'h0D5, 3, 1, 1'b1);
    testFullPage();
    testStop();
    testRestart();
    testBackToBack();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        check("watchdog", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule